// File: doc/BRIEF.md
# Two-Level Paired Event Counter

This block counts hardware events in two tiers. Four narrow local counters sit next to the event sources. Each local counter picks one event line through its own source-select code, and counts that event while the block is switched on. Eight wide global counters sit behind them. Any local counter can be tied to any global counter through a pairing field. When a paired local counter wraps, the carry advances its global partner, so the pair behaves as one 48-bit count split into a 16-bit low slice and a 32-bit high slice.

Software reaches everything through one 64-bit register port. There are registers for configuration, monitor enable, run control, overflow status and node event codes. The counters can be read and written directly in their packed form, or through four per-counter windows. A window joins a local counter with its paired global counter into one 48-bit value. When a global counter wraps, a sticky status bit is set, and an interrupt output rises while any status bit is set and interrupts are enabled.

Local counters can also be chained: counter 0 into 1, counter 2 into 3, or all four into one ripple chain. An upper counter in a chain then counts carries instead of its own event.

Top module: `paired_evt_counter`

## Requirements
- R1: After reset every register reads zero (addresses 0 to 15) and `irq` is low.
- R2: The register map is: 0 configuration, 1 monitor enable (bit 0), 2 control, 3 overflow status, 4 node event codes, 5 the local counters, 8 to 11 the global counters, and 12 to 15 the windows. Configuration, control and node event codes read back what was written. Control holds run enable at bit 0, interrupt enable at bit 1 and a grouping field at [11:8]. Node event codes hold 8 bits per local counter, with counter n at [8n+7:8n], and are driven on `node_evsel`. The configuration bits used here are: counting enable at bit 0, combine bits [3:1], pair enables at [7:4] (bit 4+n for counter n), pair targets at [16+4n+3:16+4n], and source codes at [32+8n+7:32+8n].
- R3: Source code 0x04|m selects `xp_evt[m]`. Code ((p+1)<<4)|(s<<2)|m selects `dev_evt[16p+4s+m]` for port p in 0..1 and sub-unit s in 0..3. Every other code selects nothing.
- R4: A local counter adds one on each cycle in which its selected event is high, but only while counting enable, monitor enable and run enable are all set. Otherwise it holds.
- R5: When a local counter with its pair enable set wraps from 0xFFFF to 0, the global counter named by its pair target adds one in the same cycle. A wrap with the pair enable clear, or with a target of 8 or more, leaves the global counters unchanged.
- R6: Carries from several local counters that share one global target in the same cycle are all added.
- R7: When global counter k wraps past 0xFFFFFFFF, status bit k is set and stays set. Writing 1 to a status bit clears it. A new wrap in the same cycle as the clear leaves the bit set.
- R8: `irq` is high exactly while some status bit is set and interrupt enable is set.
- R9: A window read at address 12+n returns (paired global << 16) | local n, with 0 for the global part if the target is 8 or more. A window write puts bits [15:0] into local n and bits [47:16] into the paired global counter, and leaves every other counter unchanged.
- R10: The local register packs counter n at [16n+15:16n]. Global counter k sits in register 8+(k>>1), in the low half when k is even and the high half when k is odd. Both registers are readable and writable.
- R11: Combine bit 1 chains counter 0 into 1, bit 2 chains 2 into 3, and bit 3 chains all four in order. A chained upper counter counts only the wraps of the counter below it, in the same cycle. With all combine bits clear the counters are independent.
- R12: The monitor enable reads 0 whenever all pair enables are clear. Clearing the last pair enable also clears it.
- R13: A software write to a counter in the same cycle as an increment of that counter stores the written value, and that counter produces no carry in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational from reg_addr) |
| xp_evt | input | 4 | Local crosspoint event lines |
| dev_evt | input | 32 | Device event lines, 2 ports x 4 sub-units x 4 outputs |
| node_evsel | output | 32 | Node event codes, 8 bits per local counter |
| irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of functions can land in the same cycle. In the first, a global counter wraps and sets its status bit while software writes 1 to clear that same bit. The bench provokes this by driving the event and the status write in one cycle, then expects the bit to stay set. In the second, a counter is written by software while its event is high. The bench expects the written value and no increment. A random phase also drives independent events on all four counters, with two counters sharing one global target, so that their carries and a global wrap coincide. Every window read is compared against a bench model.

// File: rtl/paired_cnt_pkg.sv
package paired_cnt_pkg;
    localparam int NLOC   = 4;
    localparam int NGLB   = 8;
    localparam int LW     = 16;
    localparam int GW     = 32;
    localparam int RW     = 64;
    localparam int SELW   = 8;
    localparam int PAIRW  = 4;
    localparam int NPORT  = 2;
    localparam int NSUB   = 4;
    localparam int NDEV   = NPORT * NSUB * NLOC;
    localparam int ADDR_W = 4;
    localparam int CMBW   = 3;

    localparam logic [ADDR_W-1:0] A_CFG = 4'd0;
    localparam logic [ADDR_W-1:0] A_MON = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTL = 4'd2;
    localparam logic [ADDR_W-1:0] A_OVF = 4'd3;
    localparam logic [ADDR_W-1:0] A_EVS = 4'd4;
    localparam logic [ADDR_W-1:0] A_LOC = 4'd5;
    localparam logic [ADDR_W-1:0] A_GLB = 4'd8;
    localparam logic [ADDR_W-1:0] A_WIN = 4'd12;

    // configuration field positions
    localparam int CF_PAIR_EN = 4;
    localparam int CF_PSEL    = 16;
    localparam int CF_INSEL   = 32;
endpackage

// File: rtl/pc_src_sel.sv
module pc_src_sel
    import paired_cnt_pkg::*;
(
    input  logic [NLOC-1:0][SELW-1:0] sel,
    input  logic [NLOC-1:0]           xp_evt,
    input  logic [NDEV-1:0]           dev_evt,
    output logic [NLOC-1:0]           ev
);
    for (genvar g = 0; g < NLOC; g++) begin : g_sel
        always_comb begin
            ev[g] = 1'b0;
            // own event: upper nibble 0, bits [3:2] = 01
            if (sel[g][7:4] == 4'd0 && sel[g][3:2] == 2'b01)
                ev[g] = xp_evt[sel[g][1:0]];
            // device output: upper nibble = port + 1
            else if (sel[g][7:4] == 4'd1 || sel[g][7:4] == 4'd2)
                ev[g] = dev_evt[{sel[g][5], sel[g][3:0]}];
        end
    end
endmodule

// File: rtl/pc_local_bank.sv
module pc_local_bank #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                count_on,
    input  logic [N-1:0]        ev,
    input  logic [N-1:0]        chain_up,
    input  logic [N-1:0]        we,
    input  logic [N-1:0][W-1:0] wval,
    output logic [N-1:0][W-1:0] cnt,
    output logic [N-1:0]        wrap
);
    typedef struct packed {
        logic [N-1:0][W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic inc;
        logic prev;
        st_d = st_q;
        wrap = '0;
        prev = 1'b0;
        for (int i = 0; i < N; i++) begin
            inc     = count_on & (chain_up[i] ? prev : ev[i]);
            wrap[i] = inc & ~we[i] & (&st_q.cnt[i]);
            prev    = wrap[i];
            st_d.cnt[i] = we[i] ? wval[i] : st_q.cnt[i] + W'(inc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_on && we == '0) |=> $stable(st_q.cnt)); // R4
endmodule

// File: rtl/pc_global_bank.sv
module pc_global_bank #(
    parameter int NL = 4,
    parameter int NG = 8,
    parameter int W  = 32,
    parameter int PW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NL-1:0]         carry,
    input  logic [NL-1:0][PW-1:0] pair_sel,
    input  logic [NG-1:0]         we,
    input  logic [NG-1:0][W-1:0]  wval,
    input  logic [NG-1:0]         w1c,
    output logic [NG-1:0][W-1:0]  cnt,
    output logic [NG-1:0]         ovf
);
    localparam int IW = $clog2(NL + 1);

    typedef struct packed {
        logic [NG-1:0][W-1:0] cnt;
        logic [NG-1:0]        ovf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [IW-1:0] inc;
        logic [W:0]    sum;
        logic          set;
        st_d = st_q;
        for (int k = 0; k < NG; k++) begin
            inc = '0;
            for (int i = 0; i < NL; i++)
                if (carry[i] && pair_sel[i] == PW'(k)) inc = inc + IW'(1);
            sum = {1'b0, st_q.cnt[k]} + (W+1)'(inc);
            set = sum[W] & ~we[k];
            st_d.cnt[k] = we[k] ? wval[k] : sum[W-1:0];
            st_d.ovf[k] = (st_q.ovf[k] & ~w1c[k]) | set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    AST_GLB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we == '0 && carry == '0) |=> $stable(st_q.cnt)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ovf & ~w1c) != '0)
        |=> ((st_q.ovf & $past(st_q.ovf & ~w1c)) == $past(st_q.ovf & ~w1c))); // R7
endmodule

// File: rtl/paired_evt_counter.sv
module paired_evt_counter
    import paired_cnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [RW-1:0]     reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    input  logic [NLOC-1:0]   xp_evt,
    input  logic [NDEV-1:0]   dev_evt,
    output logic [NLOC*SELW-1:0] node_evsel,
    output logic              irq
);
    typedef struct packed {
        logic [RW-1:0]        cfg;
        logic                 mon;
        logic                 run;
        logic                 irqen;
        logic [3:0]           grp;
        logic [NLOC*SELW-1:0] evs;
    } regs_t;

    regs_t r_d, r_q;

    logic [NLOC-1:0][PAIRW-1:0] psel;
    logic [NLOC-1:0][SELW-1:0]  insel;
    logic [NLOC-1:0]            pair_en, ev, wrap, chain_up, loc_we, win_we;
    logic [NLOC-1:0][LW-1:0]    loc_wval, loc_cnt;
    logic [NGLB-1:0]            g_we, w1c, ovf;
    logic [NGLB-1:0][GW-1:0]    g_wval, glb_cnt;
    logic [CMBW-1:0]            combine;
    logic                       count_on;

    always_comb begin
        for (int n = 0; n < NLOC; n++) begin
            psel[n]    = r_q.cfg[CF_PSEL + PAIRW*n +: PAIRW];
            insel[n]   = r_q.cfg[CF_INSEL + SELW*n +: SELW];
            pair_en[n] = r_q.cfg[CF_PAIR_EN + n];
        end
    end

    assign combine  = r_q.cfg[CMBW:1];
    assign count_on = r_q.cfg[0] & r_q.mon & r_q.run;
    assign chain_up = {combine[1] | combine[2], combine[2], combine[0] | combine[2], 1'b0};

    // register next state
    always_comb begin
        r_d = r_q;
        if (reg_we && reg_addr == A_CFG) r_d.cfg = reg_wdata;
        if (reg_we && reg_addr == A_MON) r_d.mon = reg_wdata[0];
        if (reg_we && reg_addr == A_CTL) begin
            r_d.run   = reg_wdata[0];
            r_d.irqen = reg_wdata[1];
            r_d.grp   = reg_wdata[11:8];
        end
        if (reg_we && reg_addr == A_EVS) r_d.evs = reg_wdata[NLOC*SELW-1:0];
        r_d.mon = r_d.mon & (|r_d.cfg[CF_PAIR_EN +: NLOC]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // counter write steering
    always_comb begin
        g_we   = '0;
        g_wval = '0;
        for (int n = 0; n < NLOC; n++) begin
            win_we[n]   = reg_we && reg_addr == A_WIN + ADDR_W'(n);
            loc_we[n]   = (reg_we && reg_addr == A_LOC) || win_we[n];
            loc_wval[n] = (reg_addr == A_LOC) ? reg_wdata[LW*n +: LW] : reg_wdata[LW-1:0];
        end
        for (int k = 0; k < NGLB; k++) begin
            if (reg_we && reg_addr == A_GLB + ADDR_W'(k / 2)) begin
                g_we[k]   = 1'b1;
                g_wval[k] = reg_wdata[GW*(k % 2) +: GW];
            end
        end
        for (int n = 0; n < NLOC; n++) begin
            if (win_we[n] && !psel[n][PAIRW-1]) begin
                g_we[psel[n][2:0]]   = 1'b1;
                g_wval[psel[n][2:0]] = reg_wdata[LW +: GW];
            end
        end
        w1c = (reg_we && reg_addr == A_OVF) ? reg_wdata[NGLB-1:0] : '0;
    end

    pc_src_sel u_src (
        .sel     (insel),
        .xp_evt  (xp_evt),
        .dev_evt (dev_evt),
        .ev      (ev)
    );

    pc_local_bank #(.N(NLOC), .W(LW)) u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_on (count_on),
        .ev       (ev),
        .chain_up (chain_up),
        .we       (loc_we),
        .wval     (loc_wval),
        .cnt      (loc_cnt),
        .wrap     (wrap)
    );

    pc_global_bank #(.NL(NLOC), .NG(NGLB), .W(GW), .PW(PAIRW)) u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .carry    (wrap & pair_en),
        .pair_sel (psel),
        .we       (g_we),
        .wval     (g_wval),
        .w1c      (w1c),
        .cnt      (glb_cnt),
        .ovf      (ovf)
    );

    // read mux
    always_comb begin
        logic [PAIRW-1:0] ws;
        logic [GW-1:0]    wg;
        reg_rdata = '0;
        ws = psel[reg_addr[1:0]];
        wg = ws[PAIRW-1] ? '0 : glb_cnt[ws[2:0]];
        case (reg_addr[3:2])
            2'd2: reg_rdata = {glb_cnt[{reg_addr[1:0], 1'b1}], glb_cnt[{reg_addr[1:0], 1'b0}]};
            2'd3: reg_rdata = {{(RW-GW-LW){1'b0}}, wg, loc_cnt[reg_addr[1:0]]};
            default: begin
                case (reg_addr)
                    A_CFG: reg_rdata = r_q.cfg;
                    A_MON: reg_rdata = {{(RW-1){1'b0}}, r_q.mon};
                    A_CTL: reg_rdata = {{(RW-12){1'b0}}, r_q.grp, 6'd0, r_q.irqen, r_q.run};
                    A_OVF: reg_rdata = {{(RW-NGLB){1'b0}}, ovf};
                    A_EVS: reg_rdata = {{(RW-NLOC*SELW){1'b0}}, r_q.evs};
                    A_LOC: reg_rdata = loc_cnt;
                    default: reg_rdata = '0;
                endcase
            end
        endcase
    end

    assign node_evsel = r_q.evs;
    assign irq        = (|ovf) & r_q.irqen;

    AST_MON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cfg[CF_PAIR_EN +: NLOC] == '0) |-> !r_q.mon); // R12

    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf == '0) |-> !irq); // R8
endmodule

// File: tb/paired_evt_counter_test.sv
module paired_evt_counter_test;
    localparam int CLK_T = 10;
    localparam logic [63:0] CFG_V = 64'h072E1504_725200F1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [3:0]  xp_evt = '0;
    logic [31:0] dev_evt = '0;
    logic [31:0] node_evsel;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] ml [4];
    logic [31:0] mg [8];
    logic [7:0]  movf;
    int          pr [4] = '{2, 5, 2, 7};

    always #(CLK_T/2) clk = ~clk;

    paired_evt_counter uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xp_evt(xp_evt),
        .dev_evt(dev_evt), .node_evsel(node_evsel), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] x, input logic [31:0] dv, input int cyc);
        xp_evt = x; dev_evt = dv;
        repeat (cyc) tick();
        xp_evt = '0; dev_evt = '0;
    endtask

    // bench model of one counting cycle, counters independent
    task automatic mstep(input logic [3:0] e);
        logic [3:0] cy;
        logic [32:0] s;
        int inc;
        for (int i = 0; i < 4; i++) begin
            cy[i] = e[i] && ml[i] == 16'hFFFF;
            if (e[i]) ml[i] = ml[i] + 16'd1;
        end
        for (int k = 0; k < 8; k++) begin
            inc = 0;
            for (int i = 0; i < 4; i++) if (cy[i] && pr[i] == k) inc++;
            s = {1'b0, mg[k]} + 33'(inc);
            mg[k] = s[31:0];
            if (s[32]) movf[k] = 1'b1;
        end
    endtask

    initial begin
        #(CLK_T * 190000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [3:0]  e;
        int          n;
        void'($urandom(32'd2024));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v); chk("R1 reset value", v, 64'd0);
        end
        chk("R1 irq", {63'd0, irq}, 64'd0);

        // R2 readback
        wr(4'd0, CFG_V); rd(4'd0, v); chk("R2 cfg", v, CFG_V);
        wr(4'd4, 64'hFFFF_0000_A1B2_C3D4); rd(4'd4, v); chk("R2 evsel reg", v, 64'hA1B2_C3D4);
        chk("R2 evsel pins", {32'd0, node_evsel}, 64'hA1B2_C3D4);
        wr(4'd2, 64'hF503); rd(4'd2, v); chk("R2 ctl", v, 64'h0503);
        wr(4'd2, 64'h3);

        // R12 monitor needs a pair
        wr(4'd0, CFG_V & ~64'hF0); wr(4'd1, 64'd1); rd(4'd1, v); chk("R12 mon w/o pairs", v, 64'd0);
        wr(4'd0, CFG_V); wr(4'd1, 64'd1); rd(4'd1, v); chk("R12 mon with pairs", v, 64'd1);

        // R3 source decode, R4 counting
        pulse(4'h0, 32'h0000_0020, 3);
        rd(4'd5, v); chk("R4 count dev5", v, 64'h0000_0000_0003_0000);
        pulse(4'h2, 32'h0020_0010, 2);
        rd(4'd5, v); chk("R3 unselected lines", v, 64'h0000_0000_0003_0000);
        pulse(4'h1, 32'h4000_0000, 1);
        rd(4'd5, v); chk("R3 port1 sub3 and own", v, 64'h0000_0001_0003_0001);
        wr(4'd2, 64'h2);
        pulse(4'h9, 32'h4000_0020, 2);
        rd(4'd5, v); chk("R4 run off holds", v, 64'h0000_0001_0003_0001);
        wr(4'd2, 64'h3);

        // R5 paired carry, R9 window
        wr(4'd5, 64'd0);
        wr(4'd12, 64'h0000_0000_FFFF); rd(4'd12, v); chk("R9 window write", v, 64'h0000_FFFF);
        pulse(4'h1, 32'd0, 1);
        rd(4'd12, v); chk("R5 carry to g2", v, 64'h0001_0000);
        wr(4'd0, CFG_V & ~64'h80);
        wr(4'd15, 64'h0000_0000_FFFF);
        pulse(4'h8, 32'd0, 1);
        rd(4'd5, v); chk("R5 unpaired local wraps", v, 64'd0);
        rd(4'd11, v); chk("R5 unpaired global holds", v, 64'd0);
        wr(4'd0, CFG_V);

        // R6 shared target
        wr(4'd5, 64'h0000_FFFF_0000_FFFF);
        pulse(4'h1, 32'h4000_0000, 1);
        rd(4'd9, v); chk("R6 two carries", v, 64'h0000_0000_0000_0003);

        // R9 masked window write
        wr(4'd12, 64'hABCD_1234_5678);
        rd(4'd9, v); chk("R9 neighbour global", v, 64'h0000_0000_ABCD_1234);
        rd(4'd5, v); chk("R9 neighbour locals", v, 64'h0000_0000_0000_5678);

        // R10 direct global access
        wr(4'd10, 64'h1111_2222_3333_4444); rd(4'd10, v); chk("R10 global pair", v, 64'h1111_2222_3333_4444);
        rd(4'd13, v); chk("R10 odd half via window", v, 64'h0000_1111_2222_0000);

        // R7 and R8 overflow
        wr(4'd13, 64'hFFFF_FFFF_FFFF);
        pulse(4'h0, 32'h20, 1);
        rd(4'd13, v); chk("R7 global wraps", v, 64'd0);
        rd(4'd3, v); chk("R7 status set", v, 64'h20);
        chk("R8 irq high", {63'd0, irq}, 64'd1);
        wr(4'd2, 64'h1); chk("R8 irq masked", {63'd0, irq}, 64'd0);
        wr(4'd2, 64'h3); chk("R8 irq unmasked", {63'd0, irq}, 64'd1);
        wr(4'd3, 64'h20); rd(4'd3, v); chk("R7 w1c", v, 64'd0);
        chk("R8 irq after clear", {63'd0, irq}, 64'd0);
        wr(4'd13, 64'hFFFF_FFFF_FFFF);
        dev_evt = 32'h20; reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 64'h20;
        tick();
        dev_evt = '0; reg_we = 1'b0;
        rd(4'd3, v); chk("R7 set beats clear", v, 64'h20);
        wr(4'd3, 64'hFF);

        // R13 write beats increment
        dev_evt = 32'h20; reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 64'h0042_0000;
        tick();
        dev_evt = '0; reg_we = 1'b0;
        rd(4'd5, v); chk("R13 write wins", v, 64'h0042_0000);

        // R11 chaining
        wr(4'd0, CFG_V | 64'h2); wr(4'd5, 64'h0000_FFFF);
        pulse(4'h1, 32'd0, 1);
        rd(4'd5, v); chk("R11 chain 0 into 1", v, 64'h0001_0000);
        pulse(4'h0, 32'h20, 2);
        rd(4'd5, v); chk("R11 upper ignores own event", v, 64'h0001_0000);
        wr(4'd0, CFG_V | 64'h8); wr(4'd5, 64'h0000_FFFF_FFFF_FFFF);
        pulse(4'h1, 32'd0, 1);
        rd(4'd5, v); chk("R11 chain all four", v, 64'h0001_0000_0000_0000);
        wr(4'd0, CFG_V);

        // R12 clearing last pair drops monitor
        wr(4'd0, CFG_V & ~64'hF0); rd(4'd1, v); chk("R12 mon auto clear", v, 64'd0);
        wr(4'd0, CFG_V); wr(4'd1, 64'd1);

        // random phase: R4 R5 R6 R7 against model
        wr(4'd3, 64'hFF);
        wr(4'd5, 64'hFFF0_FFF0_FFF0_FFF0);
        wr(4'd8, 64'd0);
        wr(4'd9, 64'h0000_0000_FFFF_FFFE);
        wr(4'd10, 64'hFFFF_FFFF_0000_0000);
        wr(4'd11, 64'h0000_0100_0000_0000);
        for (int i = 0; i < 4; i++) ml[i] = 16'hFFF0;
        mg = '{0, 0, 32'hFFFF_FFFE, 0, 0, 32'hFFFF_FFFF, 0, 32'h100};
        movf = '0;
        for (int c = 0; c < 3000; c++) begin
            e = 4'($urandom);
            xp_evt  = {e[3], 2'b00, e[0]};
            dev_evt = {1'b0, e[2], 24'd0, e[1], 5'd0};
            n = int'($urandom % 4);
            rd(4'(12 + n), v);
            chk("R5 random window", v, {16'd0, mg[pr[n]], ml[n]});
            tick();
            mstep(e);
        end
        xp_evt = '0; dev_evt = '0;
        rd(4'd3, v); chk("R7 random status", v, {56'd0, movf});
        chk("R8 random irq", {63'd0, irq}, {63'd0, |movf});

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule